// File: doc/BRIEF.md
# Load/Store Byte-Lane Formatter

This block sits between a 32-bit core's load/store stage and a byte-addressed data memory that is organised as 32-bit words. For a store it places the core's write data onto the right byte lanes and raises byte enables for those lanes only. For a load it reads the whole word, picks out the addressed bytes, orders them, and sign-extends or zero-extends them to a register value.

Alignment is checked when a request is accepted. A misaligned request never reaches memory. It is answered with an error code, and the address that caused the fault is kept in a register. The block uses a mixed byte order on purpose. A halfword is big-endian within itself, so the byte at the lower address lands in the upper half. A word is little-endian, so the byte at the lower address lands in the least significant position.

Every accepted request gets exactly one response, one clock cycle later. The memory is expected to return read data one cycle after its enable.

Top module: `lsu_lane_fmt`

## Requirements
- R1: A word load (req_size 2, or the reserved value 3, which behaves as a word) returns the byte at the base address in bits 7:0, base+1 in 15:8, base+2 in 23:16 and base+3 in 31:24.
- R2: A halfword load (req_size 1) returns the byte at the base address in bits 15:8 and the byte at base+1 in bits 7:0.
- R3: A byte load (req_size 0) returns the addressed byte in bits 7:0. Bits 31:8 are copies of bit 7 when req_signed is 1 and are zero when req_signed is 0.
- R4: For a halfword load, bits 31:16 are copies of bit 15 when req_signed is 1 and are zero when req_signed is 0.
- R5: Memory byte lane k (mem_be[k], mem_wdata[8k+7:8k], mem_rdata[8k+7:8k]) holds the byte at address {mem_addr, k}, where mem_addr is req_addr[ADDR_W-1:2]. A store uses the same byte order as the matching load.
- R6: A halfword access with address bit 0 set asserts no mem_en. It answers with error code 1 for a load or 2 for a store.
- R7: A word access with address bits 1:0 not both zero asserts no mem_en. It answers with error code 1 for a load or 2 for a store.
- R8: When an access faults, bad_addr shows the faulting req_addr from the response cycle onward. Otherwise bad_addr keeps its value.
- R9: A request is accepted when req_valid and req_ready are both 1. rsp_valid pulses for exactly one cycle, the cycle after acceptance, and at no other time.
- R10: A store asserts mem_be only for the lanes it writes. A faulting store asserts neither mem_we nor any enable. mem_be is zero whenever no store is issued.
- R11: A response carries either data with rsp_code 0, or rsp_code not 0 with rsp_rdata 0. Byte accesses never fault, and a store response has rsp_rdata 0.
- R12: During reset req_ready, rsp_valid and mem_en are 0 and bad_addr is cleared. From the second cycle after reset is released, req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word (3 behaves as word) |
| req_signed | input | 1 | Sign-extend a load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Formatted load result |
| rsp_code | output | 2 | 0 ok, 1 load misaligned, 2 store misaligned |
| bad_addr | output | ADDR_W | Address of the last faulting access |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Read word, valid one cycle after mem_en |

## Verification
The bench builds the block with ADDR_W set to 12. At that width a behavioural byte array can cover the whole address space. Loads therefore read back what earlier stores wrote, so the stores are checked through the block's own load path as well as at the lane outputs. The small space also lets the bench reach the very top addresses (4095, 4094, 4092), where the word address is all ones. Every size is tried at all four byte offsets, with data bytes whose top bit is set and bytes whose top bit is clear. This covers both extension modes, every fault case and every lane placement.

// File: rtl/lsu_fmt_pkg.sv
// Package: shared widths, access-size and response-code types for the
// load/store lane formatter. Assumes a 32-bit data path of byte lanes.
package lsu_fmt_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_t;

    typedef enum logic [1:0] {
        EXC_NONE        = 2'd0,
        EXC_LOAD_ALIGN  = 2'd1,
        EXC_STORE_ALIGN = 2'd2
    } exc_code_t;
endpackage

// File: rtl/lsu_align_chk.sv
// Module: alignment checker. Flags a halfword with an odd address and a
// word (or reserved size) whose address is not a multiple of four.
// Assumes byte accesses are always legal.
module lsu_align_chk
    import lsu_fmt_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);
    // Decide misalignment from size and low address bits.
    always_comb begin
        unique case (acc_size_t'(size))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            default: misaligned = |off;
        endcase
    end
endmodule

// File: rtl/lsu_store_lanes.sv
// Module: store lane placement. Produces per-lane enables and data for an
// aligned store. Assumes the caller has already rejected misaligned
// accesses; lane k is the byte at word address + k.
module lsu_store_lanes
    import lsu_fmt_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Choose enable and byte for lane g by access size.
        always_comb begin
            unique case (acc_size_t'(size))
                SZ_BYTE: begin
                    be[g]           = (off == OFF_W'(g));
                    lane_data[8*g +: 8] = wdata[7:0];
                end
                SZ_HALF: begin
                    be[g] = (off[OFF_W-1:1] == OFF_W'(g) >> 1);
                    // Lower-address byte of a halfword is its high byte.
                    lane_data[8*g +: 8] = (g % 2 == 0) ? wdata[15:8] : wdata[7:0];
                end
                default: begin
                    be[g]               = 1'b1;
                    lane_data[8*g +: 8] = wdata[8*g +: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Module: load extraction. Selects the addressed bytes of a read word,
// orders them (halfword big-endian inside, word little-endian) and
// extends to 32 bits. Assumes an aligned offset.
module lsu_load_extract
    import lsu_fmt_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic              sgn,
    output logic [DATA_W-1:0] value
);
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lanes[g] = word[8*g +: 8];
    end

    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    // Pick the addressed byte and the addressed halfword.
    always_comb begin
        sel_byte = lanes[off];
        sel_half = {lanes[{off[OFF_W-1:1], 1'b0}], lanes[{off[OFF_W-1:1], 1'b1}]};
    end

    // Extend the selected field to the full register width.
    always_comb begin
        unique case (acc_size_t'(size))
            SZ_BYTE: value = {{(DATA_W-8){sgn & sel_byte[7]}}, sel_byte};
            SZ_HALF: value = {{(DATA_W-16){sgn & sel_half[15]}}, sel_half};
            default: value = word;
        endcase
    end
endmodule

// File: rtl/lsu_lane_fmt.sv
// Module: load/store lane formatter top. Accepts one request per cycle,
// issues the memory access in the accept cycle, and answers one cycle
// later with formatted data or an alignment error. Assumes the memory
// returns read data one cycle after mem_en.
module lsu_lane_fmt
    import lsu_fmt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [1:0]        rsp_code,
    output logic [ADDR_W-1:0] bad_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    logic             ready_q;
    logic             accept;
    logic             misaligned;
    logic [LANES-1:0] st_be;
    logic [31:0]      st_data;
    logic [31:0]      ld_value;

    logic             rsp_q;
    exc_code_t        code_q;
    logic             store_q;
    logic [1:0]       size_q;
    logic [OFF_W-1:0] off_q;
    logic             sgn_q;
    logic [ADDR_W-1:0] bad_q;

    lsu_align_chk u_align (
        .size       (req_size),
        .off        (req_addr[OFF_W-1:0]),
        .misaligned (misaligned)
    );

    lsu_store_lanes u_store (
        .size      (req_size),
        .off       (req_addr[OFF_W-1:0]),
        .wdata     (req_wdata),
        .be        (st_be),
        .lane_data (st_data)
    );

    lsu_load_extract u_load (
        .word  (mem_rdata),
        .size  (size_q),
        .off   (off_q),
        .sgn   (sgn_q),
        .value (ld_value)
    );

    // Handshake: accept whenever ready is up.
    assign accept = req_valid & ready_q;

    // Memory port: only aligned accepted requests reach memory.
    always_comb begin
        mem_en    = accept & ~misaligned;
        mem_we    = mem_en & req_store;
        mem_be    = mem_we ? st_be : '0;
        mem_wdata = st_data;
        mem_addr  = req_addr[ADDR_W-1:OFF_W];
    end

    // Ready rises one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Capture per-request context for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= 1'b0;
            code_q  <= EXC_NONE;
            store_q <= 1'b0;
            size_q  <= 2'd0;
            off_q   <= '0;
            sgn_q   <= 1'b0;
        end else begin
            rsp_q <= accept;
            if (accept) begin
                code_q  <= misaligned ? (req_store ? EXC_STORE_ALIGN : EXC_LOAD_ALIGN)
                                      : EXC_NONE;
                store_q <= req_store;
                size_q  <= req_size;
                off_q   <= req_addr[OFF_W-1:0];
                sgn_q   <= req_signed;
            end
        end
    end

    // Record the faulting address of a misaligned access.
    always_ff @(posedge clk) begin
        if (!rst_n)                   bad_q <= '0;
        else if (accept && misaligned) bad_q <= req_addr;
    end

    // Response: data for a good load, code for a fault, never both.
    always_comb begin
        rsp_valid = rsp_q;
        rsp_code  = rsp_q ? code_q : EXC_NONE;
        rsp_rdata = (rsp_q && code_q == EXC_NONE && !store_q) ? ld_value : '0;
        req_ready = ready_q;
        bad_addr  = bad_q;
    end
endmodule

// File: rtl/lsu_lane_fmt_chk.sv
// Module: property checker for lsu_lane_fmt, bound to every instance.
// Assumes the encodings listed in the brief.
module lsu_lane_fmt_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic [1:0]        rsp_code,
    input logic [ADDR_W-1:0] bad_addr,
    input logic              mem_en,
    input logic              mem_we,
    input logic [3:0]        mem_be
);
    logic acc;
    assign acc = req_valid & req_ready;

    a_r6_half_odd_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_size == 2'd1 && req_addr[0]) |-> !mem_en);

    a_r7_word_unaligned_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_size[1] && req_addr[1:0] != 2'b00) |-> !mem_en);

    a_r9_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    a_r11_code_excludes_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd0) |-> rsp_rdata == 32'd0);

    a_r8_capture_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd0) |-> bad_addr == $past(req_addr));

    a_r8_hold_without_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd0) |-> $stable(bad_addr));

    a_r10_no_enable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> mem_be == 4'd0);

    a_r10_write_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en && req_store));
endmodule

bind lsu_lane_fmt lsu_lane_fmt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_store (req_store),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_code  (rsp_code),
    .bad_addr  (bad_addr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_be    (mem_be)
);

// File: tb/sim_lsu_lane_fmt.sv
module sim_lsu_lane_fmt;
    localparam int AW = 12;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_store, req_signed;
    logic [1:0]    req_size;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [1:0]    rsp_code;
    logic [AW-1:0] bad_addr;
    logic          mem_en, mem_we;
    logic [AW-3:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;

    always #2 clk = ~clk;

    lsu_lane_fmt #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_size(req_size), .req_signed(req_signed),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_code(rsp_code), .bad_addr(bad_addr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem    [NB];
    logic [7:0] shadow [NB];
    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [AW-1:0] exp_bad = '0;

    // Behavioural memory: one-cycle read, byte-enabled write (lane k = addr+k).
    always @(posedge clk) begin
        if (mem_en) begin
            for (int b = 0; b < 4; b++) begin
                mem_rdata[8*b +: 8] <= mem[{mem_addr, 2'(b)}];
                if (mem_we && mem_be[b]) mem[{mem_addr, 2'(b)}] <= mem_wdata[8*b +: 8];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One request with full reference-model prediction.
    task automatic xfer(input bit st, input int sz, input bit sg,
                        input logic [AW-1:0] a, input logic [31:0] wd);
        int n;
        bit mis;
        logic [31:0] exp_val;
        logic [3:0]  exp_be;
        logic [7:0]  exp_lane [4];
        logic [7:0]  by;
        string tag;
        n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        mis = (sz == 1) ? a[0] : (sz >= 2) ? (a[1:0] != 0) : 1'b0;
        tag = mis ? ((sz == 1) ? "R6" : "R7")
                  : (st ? "R5" : ((sz == 0) ? "R3" : (sz == 1) ? "R2/R4" : "R1"));
        // expected load value from the model's byte image
        if (sz == 0)
            exp_val = sg ? {{24{shadow[a][7]}}, shadow[a]} : {24'd0, shadow[a]};
        else if (sz == 1)
            exp_val = sg ? {{16{shadow[a][7]}}, shadow[a], shadow[a+1]}
                         : {16'd0, shadow[a], shadow[a+1]};
        else
            exp_val = {shadow[a+3], shadow[a+2], shadow[a+1], shadow[a]};
        exp_be = 4'd0;
        for (int i = 0; i < 4; i++) exp_lane[i] = 8'd0;
        if (st && !mis) begin
            for (int i = 0; i < n; i++) begin
                if (sz == 0)      by = wd[7:0];
                else if (sz == 1) by = (i == 0) ? wd[15:8] : wd[7:0];
                else              by = wd[8*i +: 8];
                exp_be[(a + AW'(i)) % 4] = 1'b1;
                exp_lane[(a + AW'(i)) % 4] = by;
                shadow[a + AW'(i)] = by;
            end
        end
        req_valid = 1; req_store = st; req_size = 2'(sz); req_signed = sg;
        req_addr = a; req_wdata = wd;
        #1;
        chk({tag, " mem_en"}, 32'(mem_en), 32'(!mis));
        chk({mis && st ? "R10" : tag, " mem_be"}, 32'(mem_be), 32'(exp_be));
        chk("R10 mem_we", 32'(mem_we), 32'(st && !mis));
        if (!mis) chk("R5 mem_addr", 32'(mem_addr), 32'(a[AW-1:2]));
        for (int b = 0; b < 4; b++)
            if (exp_be[b]) chk("R5 lane data", 32'(mem_wdata[8*b +: 8]), 32'(exp_lane[b]));
        @(negedge clk);
        req_valid = 0;
        if (mis) exp_bad = a;
        chk("R9 rsp_valid", 32'(rsp_valid), 32'd1);
        chk({tag, " rsp_code"}, 32'(rsp_code), mis ? (st ? 32'd2 : 32'd1) : 32'd0);
        chk({(mis || st) ? "R11" : tag, " rsp_rdata"}, rsp_rdata, (mis || st) ? 32'd0 : exp_val);
        chk("R8 bad_addr", 32'(bad_addr), 32'(exp_bad));
    endtask

    task automatic idle();
        req_valid = 0;
        #1 chk("R10 idle mem_be", 32'(mem_be), 32'd0);
        @(negedge clk);
        chk("R9 idle rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            mem[i]    = 8'((i * 37 + 5) ^ (i >> 3));
            shadow[i] = 8'((i * 37 + 5) ^ (i >> 3));
        end
        rst_n = 0; req_valid = 0; req_store = 0; req_size = 0; req_signed = 0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R12 ready in reset", 32'(req_ready), 32'd0);
        chk("R12 rsp in reset", 32'(rsp_valid), 32'd0);
        chk("R12 mem_en in reset", 32'(mem_en), 32'd0);
        chk("R12 bad_addr reset", 32'(bad_addr), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R12 ready after reset", 32'(req_ready), 32'd1);
        idle();
        // loads of every size, offset and extension mode
        for (int base = 0; base < 64; base += 4)
            for (int o = 0; o < 4; o++)
                for (int sz = 0; sz < 4; sz++)
                    for (int sg = 0; sg < 2; sg++)
                        xfer(0, sz, sg[0], AW'(base + o), 32'h0);
        // explicit sign cases (R3, R4)
        shadow[100] = 8'h80; mem[100] = 8'h80; shadow[101] = 8'h01; mem[101] = 8'h01;
        xfer(0, 0, 1, AW'(100), 0);
        xfer(0, 0, 0, AW'(100), 0);
        xfer(0, 1, 1, AW'(100), 0);
        xfer(0, 1, 0, AW'(100), 0);
        // stores of every size and offset, then read back
        for (int o = 0; o < 4; o++)
            for (int sz = 0; sz < 4; sz++) begin
                xfer(1, sz, 0, AW'(200 + 8 * sz + o), 32'hA1B2C3D4 ^ 32'(o * 16 + sz));
                idle();
                for (int rs = 0; rs < 3; rs++) xfer(0, rs, 1, AW'(200 + 8 * sz + (o & ~(rs == 2 ? 3 : rs))), 0);
            end
        xfer(1, 1, 0, AW'(301), 32'h1234);
        xfer(0, 2, 0, AW'(300), 0);
        // top of address space
        xfer(1, 0, 0, AW'(4095), 32'hFE);
        xfer(1, 1, 0, AW'(4094), 32'hBEEF);
        xfer(0, 2, 1, AW'(4092), 0);
        xfer(1, 2, 0, AW'(4092), 32'h89ABCDEF);
        xfer(0, 1, 1, AW'(4094), 0);
        xfer(0, 0, 1, AW'(4095), 0);
        xfer(0, 2, 0, AW'(4093), 0);
        idle();
        finish_run();
    end
endmodule